// File: doc/BRIEF.md
# Bidirectional Transmit Shift Register with Bit Test

This block is the transmit-side data register that sits between a processor's ALU and a shared system data bus. It captures a parallel word from the ALU. Each clock it can shift that word one place toward either end, or hold it. A 4-bit code picks any stored bit, and a flag reports whether that bit is set. When a write strobe is raised, the block drives the stored word onto an active-low bus.

Two control lines choose the mode, which is decoded into a named enumeration. The four modes are MODE_HOLD (neither line raised), MODE_LEFT (only the left line raised), MODE_RIGHT (only the right line raised) and MODE_LOAD (both lines raised). From any mode the next edge can move to any other, as the control lines decide. Two fill inputs supply the bit that enters the vacated end of a shift; tying them low gives zero fill. An asynchronous active-low reset clears the register and overrides every mode.

Top module: `xmit_shift_reg`

## Requirements
- R1: While `rst_n` is low, the register is cleared to all zeros at once, without waiting for a clock edge. This holds even when both control lines call for a load.
- R2: When `shl_en` and `shr_en` are both 1 at a rising edge, `word_q` takes the value of `par_in`.
- R3: When only `shl_en` is 1 at a rising edge, each bit i takes the old bit i+1, moving toward index 0. Bit 15 takes `fill_hi`.
- R4: When only `shr_en` is 1 at a rising edge, each bit i takes the old bit i-1, moving toward index 15. Bit 0 takes `fill_lo`.
- R5: When both control lines are 0, `word_q` keeps its value across rising edges whatever `par_in`, `fill_hi` and `fill_lo` do.
- R6: `bit_hit` is 1 exactly when bit number `bit_sel` (an unsigned 0..15) of the current `word_q` is 1. It follows `bit_sel` and `word_q` without a clock delay.
- R7: While `bus_wr` is 1, `bus_n` equals the bitwise inverse of `word_q`.
- R8: While `bus_wr` is 0, `bus_n` is released to all ones, the idle level of the active-low bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| shl_en | input | 1 | Shift-toward-bit-0 control |
| shr_en | input | 1 | Shift-toward-bit-15 control |
| par_in | input | 16 | Parallel word from the ALU |
| fill_hi | input | 1 | Bit entering position 15 on a left shift |
| fill_lo | input | 1 | Bit entering position 0 on a right shift |
| bit_sel | input | 4 | Index of the bit under test |
| bus_wr | input | 1 | Bus write strobe |
| word_q | output | 16 | Register contents |
| bit_hit | output | 1 | Selected bit is set |
| bus_n | output | 16 | Inverted bus data, all ones when idle |

## Verification
The hardest case to reach is a reset that arrives between clock edges while both control lines demand a load of an all-ones word. The check has to show that the clear takes effect before any edge and that the next edge does not load the word.

The bench raises the load request and pulls `rst_n` low in the middle of the low clock phase. It samples `word_q` once before the next edge and again after it. It then releases reset and checks that loading resumes. Walking bit patterns driven through both shift directions, with each fill input set in turn, prove the direction and the end that is filled.

// File: rtl/xsr_pkg.sv
package xsr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_LEFT  = 2'b01,
        MODE_RIGHT = 2'b10,
        MODE_LOAD  = 2'b11
    } xsr_mode_e;
endpackage

// File: rtl/xsr_mode_dec.sv
module xsr_mode_dec
    import xsr_pkg::*;
(
    input  logic      shl_en,
    input  logic      shr_en,
    output xsr_mode_e mode
);
    always_comb begin
        unique case ({shr_en, shl_en})
            2'b00:   mode = MODE_HOLD;
            2'b01:   mode = MODE_LEFT;
            2'b10:   mode = MODE_RIGHT;
            default: mode = MODE_LOAD;
        endcase
    end
endmodule

// File: rtl/xsr_core.sv
module xsr_core
    import xsr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xsr_mode_e        mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             fill_hi,
    input  logic             fill_lo,
    output logic [WIDTH-1:0] word_q
);
    logic [WIDTH-1:0] word_d;

    // Next-value selection, one arm per mode
    always_comb begin
        unique case (mode)
            MODE_HOLD:  word_d = word_q;
            MODE_LEFT:  word_d = {fill_hi, word_q[WIDTH-1:1]};
            MODE_RIGHT: word_d = {word_q[WIDTH-2:0], fill_lo};
            default:    word_d = par_in;
        endcase
    end

    // State register with asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    AST_LOAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOAD) |=> (word_q == $past(par_in))); // R2
    AST_LEFT_MOVES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEFT) |=> (word_q == {$past(fill_hi), $past(word_q[WIDTH-1:1])})); // R3
    AST_RIGHT_MOVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RIGHT) |=> (word_q == {$past(word_q[WIDTH-2:0]), $past(fill_lo)})); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(word_q)); // R5
endmodule

// File: rtl/xsr_bit_pick.sv
module xsr_bit_pick #(
    parameter int WIDTH = 16,
    localparam int SEL_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [WIDTH-1:0] match;

    // Decoded one-hot mask ANDed with the word, then OR-reduced
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign match[i] = word[i] && (sel == SEL_W'(i));
    end

    assign hit = |match;
endmodule

// File: rtl/xsr_bus_drv.sv
module xsr_bus_drv #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] word,
    input  logic             wr,
    output logic [WIDTH-1:0] bus_n
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_drv
        assign bus_n[i] = ~(word[i] & wr);
    end
endmodule

// File: rtl/xmit_shift_reg.sv
module xmit_shift_reg
    import xsr_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int SEL_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shl_en,
    input  logic             shr_en,
    input  logic [WIDTH-1:0] par_in,
    input  logic             fill_hi,
    input  logic             fill_lo,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             bus_wr,
    output logic [WIDTH-1:0] word_q,
    output logic             bit_hit,
    output logic [WIDTH-1:0] bus_n
);
    xsr_mode_e mode;

    xsr_mode_dec u_dec (
        .shl_en (shl_en),
        .shr_en (shr_en),
        .mode   (mode)
    );

    xsr_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .par_in  (par_in),
        .fill_hi (fill_hi),
        .fill_lo (fill_lo),
        .word_q  (word_q)
    );

    xsr_bit_pick #(.WIDTH(WIDTH)) u_pick (
        .word (word_q),
        .sel  (bit_sel),
        .hit  (bit_hit)
    );

    xsr_bus_drv #(.WIDTH(WIDTH)) u_drv (
        .word  (word_q),
        .wr    (bus_wr),
        .bus_n (bus_n)
    );

    AST_BIT_TEST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_hit == word_q[bit_sel])); // R6
    AST_BUS_DRIVE_INV: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ((bus_n ^ word_q) == {WIDTH{1'b1}})); // R7
    AST_BUS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> (bus_n == {WIDTH{1'b1}})); // R8
endmodule

// File: tb/xmit_shift_reg_tb_top.sv
module xmit_shift_reg_tb_top;
    localparam int CLK_P = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         shl_en, shr_en, fill_hi, fill_lo, bus_wr;
    logic [W-1:0] par_in;
    logic [3:0]   bit_sel;
    logic [W-1:0] word_q, bus_n;
    logic         bit_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    xmit_shift_reg dut_i (
        .clk(clk), .rst_n(rst_n), .shl_en(shl_en), .shr_en(shr_en),
        .par_in(par_in), .fill_hi(fill_hi), .fill_lo(fill_lo),
        .bit_sel(bit_sel), .bus_wr(bus_wr),
        .word_q(word_q), .bit_hit(bit_hit), .bus_n(bus_n)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with the given controls; sample 1 time unit after the edge
    task automatic step(input logic l, input logic r);
        @(negedge clk);
        shl_en = l; shr_en = r;
        @(posedge clk);
        #1;
    endtask

    task automatic load_word(input logic [W-1:0] v);
        @(negedge clk);
        par_in = v;
        step(1'b1, 1'b1);
        shl_en = 1'b0; shr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 reset clears", word_q, '0);
        check("R8 idle bus", bus_n, '1);
    endtask

    task automatic t_load();
        load_word(16'hA5C3);
        check("R2 load A5C3", word_q, 16'hA5C3);
        load_word(16'h0001);
        check("R2 load 0001", word_q, 16'h0001);
    endtask

    task automatic t_left();
        logic [W-1:0] e;
        load_word(16'h8001);
        e = 16'h8001;
        fill_hi = 1'b0;
        step(1'b1, 1'b0); e = {1'b0, e[W-1:1]};
        check("R3 left zero fill", word_q, e);
        fill_hi = 1'b1;
        step(1'b1, 1'b0); e = {1'b1, e[W-1:1]};
        check("R3 left one fill", word_q, e);
        fill_hi = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0); e = {1'b0, e[W-1:1]};
        end
        check("R3 left run", word_q, e);
        shl_en = 1'b0;
    endtask

    task automatic t_right();
        logic [W-1:0] e;
        load_word(16'h8001);
        e = 16'h8001;
        fill_lo = 1'b0;
        step(1'b0, 1'b1); e = {e[W-2:0], 1'b0};
        check("R4 right zero fill", word_q, e);
        fill_lo = 1'b1;
        step(1'b0, 1'b1); e = {e[W-2:0], 1'b1};
        check("R4 right one fill", word_q, e);
        fill_lo = 1'b0;
        shr_en = 1'b0;
    endtask

    task automatic t_hold();
        load_word(16'h3C5A);
        par_in = 16'hFFFF; fill_hi = 1'b1; fill_lo = 1'b1;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check("R5 hold ignores inputs", word_q, 16'h3C5A);
        fill_hi = 1'b0; fill_lo = 1'b0;
    endtask

    task automatic t_bit_test();
        load_word(16'h8421);
        for (int s = 0; s < W; s++) begin
            @(negedge clk);
            bit_sel = 4'(s);
            #1;
            check($sformatf("R6 bit %0d", s), {15'd0, bit_hit}, {15'd0, ((16'h8421 >> s) & 1) != 0});
        end
    endtask

    task automatic t_bus();
        load_word(16'h1234);
        @(negedge clk);
        bus_wr = 1'b1; #1;
        check("R7 bus drive inverted", bus_n, ~16'h1234);
        bus_wr = 1'b0; #1;
        check("R8 bus released", bus_n, '1);
    endtask

    task automatic t_reset_mid();
        load_word(16'h00F0);
        @(negedge clk);
        par_in = 16'hFFFF; shl_en = 1'b1; shr_en = 1'b1;
        #1 rst_n = 1'b0;
        #1;
        check("R1 async clear before edge", word_q, '0);
        @(posedge clk); #1;
        check("R1 reset beats load", word_q, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R2 load after reset", word_q, 16'hFFFF);
        shl_en = 1'b0; shr_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; shl_en = 1'b0; shr_en = 1'b0; fill_hi = 1'b0;
        fill_lo = 1'b0; bus_wr = 1'b0; par_in = '0; bit_sel = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        @(negedge clk); rst_n = 1'b1;
        t_load();
        t_left();
        t_right();
        t_hold();
        t_bit_test();
        t_bus();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule